// File: doc/BRIEF.md
# Paged Host Access Port for a Time-Slot Switch

This block is the host-facing access port of a time-slot switch. It takes a synchronous host bus (8-bit address, 16-bit write data, write strobe, read strobe) and steers each access to one of three targets: five control registers, the connection memory, or the data memory. Address bit 7 picks between register space and a 128-location channel window.

The channel window is paged. A stream field in the control register picks which of eight 128-channel pages the window covers, so the physical memory index is the stream number followed by the seven channel bits. A memory-select bit in the same register splits reads from writes. Reads return either connection memory or data memory. Writes always land in connection memory, because the host has no write path into data memory. Data memory is loaded only by the switching side, through a separate fill port.

Reads are registered. Read data and a valid pulse appear one clock after the read strobe, and the read data holds its value until the next read.

Top module: `tsw_host_port`

## Requirements
- R1: With address bit 7 low, addresses 0x01, 0x02, 0x03 and 0x04 each hold a full 16-bit value that reads back exactly as written.
- R2: The control register at 0x00 keeps only bits 2..0 (stream number, bit 2 the MSB), bit 4 (memory select) and bit 5 (block-program enable). Bits 15..6 and bit 3 always read as zero.
- R3: A synchronous active-high reset clears all five registers to zero, and clears the read data and read-valid outputs.
- R4: With address bit 7 high, the memory index is {control[2:0], address[6:0]}, covering 1024 locations. The same channel in different streams is a different location.
- R5: With memory select (control bit 4) at 0, window reads return connection memory contents.
- R6: With memory select at 1, window reads return data memory contents, zero-extended to 16 bits. Window writes still go to connection memory.
- R7: A host write through the window never changes data memory.
- R8: Register addresses 0x05 to 0x7F read as zero, and writes to them change no register.
- R9: Read data and a one-cycle valid pulse appear exactly one clock after the read strobe. With no read, the valid output stays low and the read data keeps its last value.
- R10: The fill port writes its byte into data memory at its 10-bit index. Host reads of that location see the byte when memory select is 1 and the page and channel match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Host address; bit 7 selects the memory window |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Read data, valid one clock after the strobe |
| host_rvalid | output | 1 | One-cycle pulse marking fresh read data |
| dm_fill_en | input | 1 | Switching-side data memory write enable |
| dm_fill_idx | input | 10 | Data memory index for the fill write |
| dm_fill_data | input | 8 | Byte written by the fill port |

## Verification
The assertions check the following on every cycle: the one-cycle read latency, that read data holds when no read was issued, that reset clears the read outputs, that the reserved control bits stay zero, and that unmapped register reads return zero. Only the bench scenarios can show that a page change really moves the window to different storage, and that memory select sends reads to data memory while writes still reach connection memory. The same holds for the claim that window writes leave data memory untouched: only a read-back after such a write can demonstrate it.

// File: rtl/tsw_host_pkg.sv
package tsw_host_pkg;
  // Bit positions inside the control register that the datapath decodes
  localparam int CTRL_MS_BIT = 4;
  localparam int CTRL_BP_BIT = 5;
  localparam int NUM_REGS    = 5;
  localparam int REG_CTRL    = 0;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_CM  = 2'd1,
    SRC_DM  = 2'd2
  } rd_src_e;

  function automatic logic [15:0] ctrl_keep_mask(input int stream_w);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < stream_w; i++) m[i] = 1'b1;
    m[CTRL_MS_BIT] = 1'b1;
    m[CTRL_BP_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tsw_ram.sv
module tsw_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port, read-first on collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tsw_reg_bank.sv
module tsw_reg_bank
  import tsw_host_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 7,
  parameter int STREAM_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q,
  output logic [DATA_W-1:0] ctrl
);
  localparam logic [15:0] CTRL_MASK16 = ctrl_keep_mask(STREAM_W);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(CTRL_MASK16);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] rd_sel;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = (g == REG_CTRL) ? CTRL_MASK : '1;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                q <= '0;
      else if (wr_en && idx == IDX_W'(g))     q <= wdata & MASK;
    end
    assign regs[g] = q;
  end

  assign ctrl = regs[REG_CTRL];

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) rd_sel = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_sel;
  end

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctrl & ~CTRL_MASK) == '0); // R2

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx >= IDX_W'(NUM_REGS)) |=> rdata_q == '0); // R8
endmodule

// File: rtl/tsw_host_port.sv
module tsw_host_port
  import tsw_host_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DM_W     = 8,
  parameter int CH_W     = 7,
  parameter int STREAM_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CH_W:0]              host_addr,
  input  logic [DATA_W-1:0]          host_wdata,
  input  logic                       host_wr,
  input  logic                       host_rd,
  output logic [DATA_W-1:0]          host_rdata,
  output logic                       host_rvalid,
  input  logic                       dm_fill_en,
  input  logic [STREAM_W+CH_W-1:0]   dm_fill_idx,
  input  logic [DM_W-1:0]            dm_fill_data
);
  localparam int MEM_AW = STREAM_W + CH_W;

  logic                is_mem;
  logic [CH_W-1:0]     chan;
  logic [DATA_W-1:0]   ctrl;
  logic                mem_sel;
  logic [MEM_AW-1:0]   mem_idx;
  logic [DATA_W-1:0]   reg_q;
  logic [DATA_W-1:0]   cm_q;
  logic [DM_W-1:0]     dm_q;
  rd_src_e             src_q;
  logic                rvalid_q;

  assign is_mem  = host_addr[CH_W];
  assign chan    = host_addr[CH_W-1:0];
  assign mem_sel = ctrl[CTRL_MS_BIT];
  assign mem_idx = {ctrl[STREAM_W-1:0], chan};

  tsw_reg_bank #(
    .DATA_W  (DATA_W),
    .IDX_W   (CH_W),
    .STREAM_W(STREAM_W)
  ) regs_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (host_wr & ~is_mem),
    .rd_en  (host_rd & ~is_mem),
    .idx    (chan),
    .wdata  (host_wdata),
    .rdata_q(reg_q),
    .ctrl   (ctrl)
  );

  // Connection memory: host writes always land here
  tsw_ram #(.AW(MEM_AW), .DW(DATA_W)) cm_i (
    .clk  (clk),
    .we   (host_wr & is_mem),
    .waddr(mem_idx),
    .wdata(host_wdata),
    .re   (host_rd & is_mem & ~mem_sel),
    .raddr(mem_idx),
    .rdata(cm_q)
  );

  // Data memory: written only by the switching side
  tsw_ram #(.AW(MEM_AW), .DW(DM_W)) dm_i (
    .clk  (clk),
    .we   (dm_fill_en),
    .waddr(dm_fill_idx),
    .wdata(dm_fill_data),
    .re   (host_rd & is_mem & mem_sel),
    .raddr(mem_idx),
    .rdata(dm_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= SRC_REG;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= host_rd;
      if (host_rd)
        src_q <= !is_mem ? SRC_REG : (mem_sel ? SRC_DM : SRC_CM);
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_CM:  host_rdata = cm_q;
      SRC_DM:  host_rdata = DATA_W'(dm_q);
      default: host_rdata = reg_q;
    endcase
  end

  assign host_rvalid = rvalid_q;

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid); // R9

  AST_READ_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(host_rd) && !$past(rst)) |-> $stable(host_rdata)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (host_rdata == '0 && !host_rvalid)); // R3
endmodule

// File: tb/tsw_host_port_tb.sv
module tsw_host_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_rdata;
  logic        host_rvalid;
  logic        dm_fill_en = 1'b0;
  logic [9:0]  dm_fill_idx = '0;
  logic [7:0]  dm_fill_data = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { logic [15:0] d; string req; } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  tsw_host_port dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .dm_fill_en(dm_fill_en),
    .dm_fill_idx(dm_fill_idx), .dm_fill_data(dm_fill_data)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, input logic [15:0] e, input string req);
    exp_t it;
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    it.d = e; it.req = req;
    expq.push_back(it);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic dm_fill(input logic [9:0] i, input logic [7:0] d);
    @(negedge clk);
    dm_fill_idx = i; dm_fill_data = d; dm_fill_en = 1'b1;
    @(negedge clk);
    dm_fill_en = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input int stream, input bit ms);
    return 16'((ms ? 16 : 0) + stream);
  endfunction

  // Monitor: compare each valid read against the scoreboard
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected valid", host_rdata, 16'h0);
      end else begin
        exp_t it;
        it = expq.pop_front();
        check(host_rdata === it.d, it.req, host_rdata, it.d);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(host_rdata === 16'h0, "R3 rdata after reset", host_rdata, 16'h0);
    check(host_rvalid === 1'b0, "R3 rvalid after reset", 16'(host_rvalid), 16'h0);
    host_read(8'h00, 16'h0000, "R3 ctrl reset value");
    host_read(8'h03, 16'h0000, "R3 offset reg reset value");

    // R2: reserved control bits
    host_write(8'h00, 16'hFFFF);
    host_read(8'h00, 16'h0037, "R2 ctrl keeps only defined bits");
    repeat (3) @(negedge clk);
    check(host_rvalid === 1'b0, "R9 no valid when idle", 16'(host_rvalid), 16'h0);
    check(host_rdata === 16'h0037, "R9 rdata holds when idle", host_rdata, 16'h0037);

    // R1: full-width registers
    host_write(8'h01, 16'h1234);
    host_write(8'h02, 16'hBEEF);
    host_write(8'h03, 16'h0A0A);
    host_write(8'h04, 16'h5555);
    host_read(8'h01, 16'h1234, "R1 reg 0x01");
    host_read(8'h02, 16'hBEEF, "R1 reg 0x02");
    host_read(8'h03, 16'h0A0A, "R1 reg 0x03");
    host_read(8'h04, 16'h5555, "R1 reg 0x04");

    // R8: unmapped register addresses
    host_write(8'h05, 16'hFFFF);
    host_write(8'h7F, 16'hA5A5);
    host_read(8'h05, 16'h0000, "R8 read 0x05 is zero");
    host_read(8'h7F, 16'h0000, "R8 read 0x7F is zero");
    host_read(8'h01, 16'h1234, "R8 write to 0x05 left 0x01 intact");
    host_read(8'h04, 16'h5555, "R8 write to 0x7F left 0x04 intact");
    host_read(8'h00, 16'h0037, "R8 ctrl intact after unmapped writes");

    // R4/R5: paging into connection memory
    host_write(8'h00, ctl(0, 0));
    host_write(8'h83, 16'h1111);
    host_write(8'h00, ctl(5, 0));
    host_write(8'h83, 16'h5555);
    host_read(8'h83, 16'h5555, "R5 stream 5 ch 3 from connection memory");
    host_write(8'h00, ctl(0, 0));
    host_read(8'h83, 16'h1111, "R4 stream 0 ch 3 is a separate location");
    host_write(8'h00, ctl(7, 0));
    host_write(8'hFF, 16'hCAFE);
    host_write(8'h80, 16'hBEAD);
    host_read(8'hFF, 16'hCAFE, "R4 top index stream 7 ch 127");
    host_read(8'h80, 16'hBEAD, "R4 stream 7 ch 0");

    // R10/R6: data memory through fill port and memory select
    dm_fill(10'd643, 8'hA5);   // stream 5, ch 3
    dm_fill(10'd3,   8'h3C);   // stream 0, ch 3
    host_write(8'h00, ctl(5, 1));
    host_read(8'h83, 16'h00A5, "R10 fill visible at stream 5 ch 3");
    host_write(8'h00, ctl(0, 1));
    host_read(8'h83, 16'h003C, "R6 read with select=1 returns data memory");

    // R7/R6: window write with select=1 goes to connection memory only
    host_write(8'h83, 16'h7777);
    host_read(8'h83, 16'h003C, "R7 data memory unchanged by host write");
    host_write(8'h00, ctl(0, 0));
    host_read(8'h83, 16'h7777, "R6 write with select=1 reached connection memory");

    // R3: reset mid-run clears registers
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(host_rdata === 16'h0, "R3 rdata after second reset", host_rdata, 16'h0);
    host_read(8'h00, 16'h0000, "R3 ctrl cleared");
    host_read(8'h01, 16'h0000, "R3 reg 0x01 cleared");
    host_read(8'h02, 16'h0000, "R3 reg 0x02 cleared");
    host_read(8'h04, 16'h0000, "R3 reg 0x04 cleared");

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R9 every read produced a valid", 16'(expq.size()), 16'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule